// File: doc/BRIEF.md
# Halt Mode Clock Controller

This block puts a fully static core into a low-power halt state and brings it back out. Software requests halt by writing a one to a dedicated control bit. From the next cycle the block holds the core clock gate closed and drops the oscillator enable, so every piece of core state stays frozen where it was.

Halt ends in one of two ways. An active-low reset pin makes the core restart from address zero. A low-to-high edge on the wake pin makes the core resume at the instruction after the one that requested halt. The wake edge only counts when the oscillator-mode strap selects an external clock or an RC oscillator. The wake edge is caught by a flop that does not need the clock, and it turns the oscillator back on at once. The core clock then stays gated for a fixed startup count so that the oscillator can settle. When the clock is released, the block pulses a strobe that clears the halt control bit and flags which kind of exit occurred. After a pin wake it also marks the first fetch slot as a synchronizing no-op. In RC mode the wake pin also serves the core as a synchronized general-purpose input.

Top module: `halt_clk_ctrl`

## Requirements
- R1: After `rst`, `core_clk_en` and `osc_en` are 1. `halt_clr`, `resume_pulse`, `restart_pulse` and `nop_slot` are 0.
- R2: While running, a cycle with `halt_wr`=1 and `halt_wdata`=1 drops `core_clk_en` and `osc_en` to 0 from the next cycle. A write with `halt_wdata`=0 leaves `core_clk_en` at 1.
- R3: While halted, `ext_rst_n`=0 drives `osc_en` to 1 without waiting for a clock edge. It ends halt with a one-cycle `restart_pulse` together with a one-cycle `halt_clr`.
- R4: While halted with `osc_mode` 2'b01 (external clock) or 2'b10 (RC), a rising edge on `wake_pin` ends halt. The exit gives a one-cycle `resume_pulse` together with `halt_clr`, and `restart_pulse` stays 0.
- R5: In the modes of R4, `osc_en` rises as soon as the wake edge arrives, without waiting for a clock edge.
- R6: `core_clk_en` returns to 1 exactly SYNC_STAGES+1+STARTUP_CYCLES rising clock edges after the exit event (19 with defaults). The exit strobes appear in that same first running cycle.
- R7: `nop_slot` is 1 for NOP_CYCLES cycles, starting with the cycle of `resume_pulse`. It stays 0 after a reset exit.
- R8: With `osc_mode` 2'b00 (crystal) or 2'b11 (reserved), wake edges are ignored: `osc_en` and `core_clk_en` both stay 0.
- R9: With `osc_mode` 2'b10, `gpi_out` follows `wake_pin` delayed by SYNC_STAGES rising edges. In the other modes `gpi_out` is 0.
- R10: A `wake_pin` that is already high when halt is entered does not wake the core. Only a later low-to-high edge does.
- R11: If reset and a wake edge end halt together, the exit is a restart: `restart_pulse` is 1 and `resume_pulse` and `nop_slot` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock feeding the block |
| rst | input | 1 | Synchronous active-high power-on reset of the block |
| halt_wr | input | 1 | Write strobe to the halt control bit |
| halt_wdata | input | 1 | Value written to the halt control bit |
| ext_rst_n | input | 1 | Active-low reset pin of the core |
| wake_pin | input | 1 | Wake pin, edge sensitive during halt |
| osc_mode | input | 2 | Oscillator strap: 00 crystal, 01 external, 10 RC, 11 reserved |
| core_clk_en | output | 1 | Core clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| halt_clr | output | 1 | One-cycle strobe that clears the halt control bit |
| resume_pulse | output | 1 | Exit by pin wake: continue after the halt request |
| restart_pulse | output | 1 | Exit by reset: start from address zero |
| nop_slot | output | 1 | First fetch slot after a pin wake runs as a no-op |
| gpi_out | output | 1 | Synchronized wake pin as general input (RC mode) |

## Verification
The hardest cases all depend on when the wake pin moves relative to halt entry and to the reset pin. A wake level that is already high when halt starts must be ignored. A wake edge in crystal mode sets the latch but must have no effect. A reset and a wake edge that land on the same edge must resolve to a restart. The stimulus drives the pins directly while the core clock is gated. It probes `osc_en` one time step after each pin change, to show the asynchronous path. It then counts clock edges until the gate reopens and checks the strobes in that cycle.

// File: rtl/halt_clk_pkg.sv
package halt_clk_pkg;

    typedef enum logic [1:0] {
        OSC_XTAL = 2'b00,
        OSC_EXT  = 2'b01,
        OSC_RC   = 2'b10,
        OSC_RSVD = 2'b11
    } osc_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_HALT  = 2'b01,
        ST_START = 2'b10
    } hstate_e;

    typedef enum logic {
        EXIT_WAKE    = 1'b0,
        EXIT_RESTART = 1'b1
    } exit_cause_e;

    typedef struct packed {
        logic resume;
        logic restart;
        logic clr;
    } exit_strobe_t;

    function automatic logic pin_wake_ok(input logic [1:0] mode);
        return (mode == OSC_EXT) || (mode == OSC_RC);
    endfunction

    function automatic logic gpi_ok(input logic [1:0] mode);
        return mode == OSC_RC;
    endfunction

endpackage

// File: rtl/halt_clk_sync.sv
module halt_clk_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= RST_VAL;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/halt_clk_wake_latch.sv
module halt_clk_wake_latch (
    input  logic wake_pin,
    input  logic clr,
    output logic flag
);
    // Set by the pin edge itself; no clock needed while the oscillator is off.
    always_ff @(posedge wake_pin or posedge clr) begin
        if (clr) flag <= 1'b0;
        else     flag <= 1'b1;
    end
endmodule

// File: rtl/halt_clk_startup.sv
module halt_clk_startup #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic done
);
    localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [W-1:0] LAST = W'(CYCLES - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)  cnt <= '0;
        else if (!done)  cnt <= cnt + 1'b1;
    end

    assign done = en && (cnt == LAST);

    // R6
    startup_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !en);
endmodule

// File: rtl/halt_clk_ctrl.sv
module halt_clk_ctrl
    import halt_clk_pkg::*;
#(
    parameter int STARTUP_CYCLES = 16,
    parameter int SYNC_STAGES    = 2,
    parameter int NOP_CYCLES     = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_wr,
    input  logic       halt_wdata,
    input  logic       ext_rst_n,
    input  logic       wake_pin,
    input  logic [1:0] osc_mode,
    output logic       core_clk_en,
    output logic       osc_en,
    output logic       halt_clr,
    output logic       resume_pulse,
    output logic       restart_pulse,
    output logic       nop_slot,
    output logic       gpi_out
);
    localparam int NW = (NOP_CYCLES > 0) ? $clog2(NOP_CYCLES + 1) : 1;
    localparam logic [NW-1:0] NOP_LOAD = NW'(NOP_CYCLES);

    hstate_e      state_q, state_d;
    exit_cause_e  cause_q, cause_d;
    exit_strobe_t strobe_q, strobe_d;
    logic         latch_clr_q;
    logic         wake_flag, wake_flag_s, rst_n_s, pin_s;
    logic         tmr_done, wake_ok, wake_evt, rst_evt;
    logic [NW-1:0] nop_cnt;

    halt_clk_wake_latch u_latch (
        .wake_pin (wake_pin),
        .clr      (latch_clr_q),
        .flag     (wake_flag)
    );

    halt_clk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_flag (
        .clk (clk), .rst (rst), .d (wake_flag), .q (wake_flag_s)
    );

    halt_clk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rst (
        .clk (clk), .rst (rst), .d (ext_rst_n), .q (rst_n_s)
    );

    halt_clk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pin (
        .clk (clk), .rst (rst), .d (wake_pin), .q (pin_s)
    );

    halt_clk_startup #(.CYCLES(STARTUP_CYCLES)) u_startup (
        .clk  (clk),
        .rst  (rst),
        .en   (state_q == ST_START),
        .done (tmr_done)
    );

    assign wake_ok  = pin_wake_ok(osc_mode);
    assign wake_evt = wake_flag_s && wake_ok;
    assign rst_evt  = !rst_n_s;

    always_comb begin
        state_d  = state_q;
        cause_d  = cause_q;
        strobe_d = '0;
        unique case (state_q)
            ST_RUN: begin
                if (halt_wr && halt_wdata) state_d = ST_HALT;
            end
            ST_HALT: begin
                // reset outranks a simultaneous wake
                if (rst_evt) begin
                    state_d = ST_START;
                    cause_d = EXIT_RESTART;
                end else if (wake_evt) begin
                    state_d = ST_START;
                    cause_d = EXIT_WAKE;
                end
            end
            ST_START: begin
                if (tmr_done) begin
                    state_d          = ST_RUN;
                    strobe_d.clr     = 1'b1;
                    strobe_d.resume  = (cause_q == EXIT_WAKE);
                    strobe_d.restart = (cause_q == EXIT_RESTART);
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_RUN;
            cause_q     <= EXIT_WAKE;
            strobe_q    <= '0;
            latch_clr_q <= 1'b1;
            nop_cnt     <= '0;
        end else begin
            state_q     <= state_d;
            cause_q     <= cause_d;
            strobe_q    <= strobe_d;
            latch_clr_q <= (state_d != ST_HALT);
            if (strobe_d.resume)   nop_cnt <= NOP_LOAD;
            else if (nop_cnt != 0) nop_cnt <= nop_cnt - 1'b1;
        end
    end

    assign core_clk_en   = (state_q == ST_RUN);
    assign osc_en        = (state_q != ST_HALT) || !ext_rst_n || (wake_flag && wake_ok);
    assign halt_clr      = strobe_q.clr;
    assign resume_pulse  = strobe_q.resume;
    assign restart_pulse = strobe_q.restart;
    assign nop_slot      = (nop_cnt != 0);
    assign gpi_out       = gpi_ok(osc_mode) && pin_s;

    // R2
    halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_wr && halt_wdata && core_clk_en) |=> !core_clk_en);

    // R11
    exit_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({resume_pulse, restart_pulse}));

    // R4
    clr_pair_chk: assert property (@(posedge clk) disable iff (rst)
        halt_clr |-> (resume_pulse || restart_pulse));

    // R6
    release_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_clk_en) |-> halt_clr);

    // R7
    nop_gate_chk: assert property (@(posedge clk) disable iff (rst)
        nop_slot |-> (core_clk_en && !restart_pulse));
endmodule

// File: tb/halt_clk_ctrl_tb.sv
module halt_clk_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int RELEASE    = 2 + 1 + 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       halt_wr = 1'b0, halt_wdata = 1'b0;
    logic       ext_rst_n = 1'b1, wake_pin = 1'b0;
    logic [1:0] osc_mode = 2'b01;
    logic       core_clk_en, osc_en, halt_clr, resume_pulse, restart_pulse, nop_slot, gpi_out;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    halt_clk_ctrl u_dut (
        .clk (clk), .rst (rst), .halt_wr (halt_wr), .halt_wdata (halt_wdata),
        .ext_rst_n (ext_rst_n), .wake_pin (wake_pin), .osc_mode (osc_mode),
        .core_clk_en (core_clk_en), .osc_en (osc_en), .halt_clr (halt_clr),
        .resume_pulse (resume_pulse), .restart_pulse (restart_pulse),
        .nop_slot (nop_slot), .gpi_out (gpi_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] mode);
        @(negedge clk);
        rst = 1'b1; osc_mode = mode; wake_pin = 1'b0; ext_rst_n = 1'b1;
        halt_wr = 1'b0; halt_wdata = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic enter_halt();
        halt_wr = 1'b1; halt_wdata = 1'b1;
        @(negedge clk);
        halt_wr = 1'b0; halt_wdata = 1'b0;
    endtask

    // counts edges from an event applied at a negedge until the gate reopens
    task automatic wait_release(output int k);
        k = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            k++;
            if (core_clk_en) break;
        end
    endtask

    task automatic t_reset_state();
        do_reset(2'b01);
        chk("R1 core_clk_en", core_clk_en, 1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 strobes", {halt_clr, resume_pulse, restart_pulse, nop_slot}, 0);
    endtask

    task automatic t_entry();
        do_reset(2'b01);
        halt_wr = 1'b1; halt_wdata = 1'b0;
        @(negedge clk);
        halt_wr = 1'b0;
        @(negedge clk);
        chk("R2 write zero keeps running", core_clk_en, 1);
        enter_halt();
        chk("R2 core_clk_en gated", core_clk_en, 0);
        chk("R2 osc_en off", osc_en, 0);
    endtask

    task automatic t_pin_wake(input logic [1:0] mode);
        int k;
        do_reset(mode);
        enter_halt();
        repeat (3) @(negedge clk);
        chk("R2 still halted", core_clk_en, 0);
        wake_pin = 1'b1;
        #1;
        chk("R5 osc_en from wake edge", osc_en, 1);
        wait_release(k);
        chk("R6 wake release edges", k, RELEASE);
        chk("R4 resume_pulse", resume_pulse, 1);
        chk("R4 halt_clr", halt_clr, 1);
        chk("R4 restart_pulse low", restart_pulse, 0);
        chk("R7 nop_slot set", nop_slot, 1);
        @(negedge clk);
        chk("R4 resume one cycle", resume_pulse, 0);
        chk("R7 nop_slot one cycle", nop_slot, 0);
        wake_pin = 1'b0;
    endtask

    task automatic t_ignored_mode(input logic [1:0] mode);
        int k;
        do_reset(mode);
        enter_halt();
        wake_pin = 1'b1;
        #1;
        chk("R8 osc_en stays off", osc_en, 0);
        repeat (40) @(negedge clk);
        chk("R8 core stays halted", core_clk_en, 0);
        chk("R8 osc_en still off", osc_en, 0);
        ext_rst_n = 1'b0;
        #1;
        chk("R3 osc_en from reset pin", osc_en, 1);
        wait_release(k);
        chk("R6 reset release edges", k, RELEASE);
        chk("R3 restart_pulse", restart_pulse, 1);
        chk("R3 halt_clr", halt_clr, 1);
        chk("R7 no nop after restart", nop_slot, 0);
        ext_rst_n = 1'b1;
        @(negedge clk);
        chk("R3 restart one cycle", restart_pulse, 0);
        wake_pin = 1'b0;
    endtask

    task automatic t_level_high();
        int k;
        do_reset(2'b01);
        wake_pin = 1'b1;
        @(negedge clk);
        enter_halt();
        repeat (30) @(negedge clk);
        chk("R10 high level does not wake", core_clk_en, 0);
        wake_pin = 1'b0;
        @(negedge clk);
        wake_pin = 1'b1;
        wait_release(k);
        chk("R10 new edge wakes", k, RELEASE);
        chk("R10 resume after new edge", resume_pulse, 1);
        wake_pin = 1'b0;
    endtask

    task automatic t_both();
        int k;
        do_reset(2'b10);
        enter_halt();
        @(negedge clk);
        ext_rst_n = 1'b0; wake_pin = 1'b1;
        wait_release(k);
        chk("R11 release edges", k, RELEASE);
        chk("R11 restart wins", restart_pulse, 1);
        chk("R11 no resume", resume_pulse, 0);
        chk("R11 no nop", nop_slot, 0);
        ext_rst_n = 1'b1; wake_pin = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_gpi();
        do_reset(2'b10);
        wake_pin = 1'b1;
        @(negedge clk);
        chk("R9 gpi after one edge", gpi_out, 0);
        @(negedge clk);
        chk("R9 gpi after two edges", gpi_out, 1);
        wake_pin = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 gpi follows low", gpi_out, 0);
        do_reset(2'b01);
        wake_pin = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 gpi off outside RC", gpi_out, 0);
        wake_pin = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_entry();
        t_pin_wake(2'b01);
        t_pin_wake(2'b10);
        t_ignored_mode(2'b00);
        t_ignored_mode(2'b11);
        t_level_high();
        t_both();
        t_gpi();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule